// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Controller

This block watches a set of input lines and turns their transitions into interrupt requests and event pulses for two processors. Each line passes through a two-flop synchronizer, after which a rising and/or falling transition is detected according to two per-line enable bits. A detected transition, or a software trigger written through the register port, is called a trigger. A trigger sets the line's pending flag in both processors' pending registers. Each processor then sees an interrupt while any of its pending flags is set and its interrupt mask bit for that line is set.

Alongside the interrupt path, each processor has an event mask. A trigger on a line whose event mask bit is set produces a one-cycle event pulse for that processor. The event pulse leaves no state behind. Each processor clears its own pending flags by writing ones. The sixteen lowest lines take their input from one of several pin ports, chosen per line by a 4-bit select field. The upper lines come from dedicated auxiliary inputs.

Software reaches the block through a flat register port. It writes one word per clock, and reads return combinationally from the addressed register.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 and irq_c0, irq_c1, evt_c0 and evt_c1 are low. Reset is asserted asynchronously and released two clocks after rst_n rises.
- R2: Register map, by word address: 0 rising-enable, 1 falling-enable, 2 software trigger, 3/4/5 core-0 interrupt mask, event mask and pending, 6/7/8 the same three for core 1, 9 to 12 port select. Line n is bit n of each per-line register. Per-line registers read back their low NUM_LINES bits. Address 2 and unused addresses read 0, and writes to unused addresses have no effect.
- R3: A line input change is seen after the synchronizer. With rising-enable set, a 0-to-1 change sets the line's pending bit in both cores. The bit is visible after the third rising clock edge that follows the input change.
- R4: With falling-enable set, a 1-to-0 change triggers the line. With both enables set, either change triggers it. With an enable clear, that direction of change sets nothing.
- R5: Pending bits are set whatever the masks hold. irq_cK is high exactly when core K has a pending bit whose interrupt-mask bit is also set.
- R6: A trigger on a line whose core-K event-mask bit is set drives evt_cK high for exactly one cycle, starting at the same edge that sets the pending bit. An event mask alone never raises irq_cK.
- R7: Writing 1 to bit n of a core's pending register clears that core's bit n. Writing 0 leaves it unchanged, and the other core's pending register is unaffected.
- R8: Writing 1 to bit n of the software-trigger register sets bit n in both cores' pending registers at that write edge. It also raises the event pulse of each core whose event mask has bit n set.
- R9: A trigger arriving in the same cycle as a write-1 clear of that line leaves the pending bit set.
- R10: Line n below 16 takes its input from port_pins[p*16+n], where p is the 4-bit field at bits 4*(n mod 4) of select register 9+n/4. A field value of NUM_PORTS or more ties the line low.
- R11: Line n of 16 or more takes its input from aux_lines[n-16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register word address |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for reg_addr |
| port_pins | input | NUM_PORTS*PORT_LINES (64) | Pin ports, port p pin n at p*16+n |
| aux_lines | input | NUM_LINES-PORT_LINES (8) | Inputs of lines 16 and up |
| irq_c0 | output | 1 | Core-0 interrupt request |
| irq_c1 | output | 1 | Core-1 interrupt request |
| evt_c0 | output | 1 | Core-0 event pulse |
| evt_c1 | output | 1 | Core-1 event pulse |

## Verification
Some internal faults show up at the ports at once. A lost or stuck pending bit shows in the pending read-back and on irq_cK in the cycle after the edge that should have changed it. A wrong synchronizer depth shifts the pending set by a whole cycle from the third edge after the input change, and the timed reads catch that shift. A clear that leaks across cores, or a select field decoded at the wrong offset, appears as a wrong bit in the other core's pending register or as a trigger from the wrong pin. A missing or stretched event shows in the two cycles that follow the trigger.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int unsigned NUM_CORES   = 2;
  localparam int unsigned SEL_REG_W   = 16;
  // word addresses of the register port
  localparam int unsigned RA_RISE     = 0;
  localparam int unsigned RA_FALL     = 1;
  localparam int unsigned RA_SWTRIG   = 2;
  localparam int unsigned RA_CORE_BASE = 3;   // per core: imask, emask, pend
  localparam int unsigned RA_CORE_STEP = 3;
  localparam int unsigned RA_SEL_BASE  = 9;

  function automatic int unsigned imask_addr(input int unsigned core);
    return RA_CORE_BASE + core * RA_CORE_STEP;
  endfunction
  function automatic int unsigned emask_addr(input int unsigned core);
    return RA_CORE_BASE + core * RA_CORE_STEP + 1;
  endfunction
  function automatic int unsigned pend_addr(input int unsigned core);
    return RA_CORE_BASE + core * RA_CORE_STEP + 2;
  endfunction
endpackage

// File: rtl/eic_port_mux.sv
module eic_port_mux #(
  parameter int unsigned NUM_LINES  = 24,
  parameter int unsigned PORT_LINES = 16,
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned SEL_W      = 4
) (
  input  logic [NUM_PORTS*PORT_LINES-1:0]        port_pins,
  input  logic [NUM_LINES-PORT_LINES-1:0]        aux_lines,
  input  logic [PORT_LINES-1:0][SEL_W-1:0]       sel,
  output logic [NUM_LINES-1:0]                   line_raw
);
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    if (n < PORT_LINES) begin : g_ported
      always_comb begin
        line_raw[n] = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (sel[n] == SEL_W'(p)) line_raw[n] = port_pins[p*PORT_LINES + n];
        end
      end
    end else begin : g_aux
      assign line_raw[n] = aux_lines[n - PORT_LINES];
    end
  end
endmodule

// File: rtl/eic_edge_detect.sv
module eic_edge_detect #(
  parameter int unsigned NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_raw,
  input  logic [NUM_LINES-1:0] rise_en,
  input  logic [NUM_LINES-1:0] fall_en,
  output logic [NUM_LINES-1:0] rise_hit,
  output logic [NUM_LINES-1:0] fall_hit
);
  logic [NUM_LINES-1:0] meta_q, meta_d;
  logic [NUM_LINES-1:0] sync_q, sync_d;
  logic [NUM_LINES-1:0] prev_q, prev_d;

  always_comb begin
    meta_d = line_raw;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_hit
    assign rise_hit[n] = rise_en[n] &  sync_q[n] & ~prev_q[n];
    assign fall_hit[n] = fall_en[n] & ~sync_q[n] &  prev_q[n];
  end
endmodule

// File: rtl/eic_core_bank.sv
module eic_core_bank #(
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned IMASK_A   = 3,
  parameter int unsigned EMASK_A   = 4,
  parameter int unsigned PEND_A    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_LINES-1:0] wdata,
  input  logic [NUM_LINES-1:0] trig,
  output logic [NUM_LINES-1:0] imask,
  output logic [NUM_LINES-1:0] emask,
  output logic [NUM_LINES-1:0] pend,
  output logic                 irq,
  output logic                 evt
);
  logic [NUM_LINES-1:0] imask_q, imask_d, emask_q, emask_d, pend_q, pend_d, clr;
  logic imask_en, emask_en, evt_q, evt_d;

  always_comb begin
    imask_en = we && (addr == ADDR_W'(IMASK_A));
    emask_en = we && (addr == ADDR_W'(EMASK_A));
    clr      = (we && (addr == ADDR_W'(PEND_A))) ? wdata : '0;
    imask_d  = wdata;
    emask_d  = wdata;
    // a trigger wins over a clear in the same cycle
    pend_d   = (pend_q & ~clr) | trig;
    evt_d    = |(trig & emask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_q <= '0;
      emask_q <= '0;
      pend_q  <= '0;
      evt_q   <= 1'b0;
    end else begin
      if (imask_en) imask_q <= imask_d;
      if (emask_en) emask_q <= emask_d;
      pend_q <= pend_d;
      evt_q  <= evt_d;
    end
  end

  assign imask = imask_q;
  assign emask = emask_q;
  assign pend  = pend_q;
  assign irq   = |(pend_q & imask_q);
  assign evt   = evt_q;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 24,
  parameter int unsigned PORT_LINES = 16,
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned SEL_W      = 4,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_we,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic [DATA_W-1:0]               reg_wdata,
  output logic [DATA_W-1:0]               reg_rdata,
  input  logic [NUM_PORTS*PORT_LINES-1:0] port_pins,
  input  logic [NUM_LINES-PORT_LINES-1:0] aux_lines,
  output logic                            irq_c0,
  output logic                            irq_c1,
  output logic                            evt_c0,
  output logic                            evt_c1
);
  localparam int unsigned FIELDS_PER_REG = SEL_REG_W / SEL_W;
  localparam int unsigned SEL_REGS       = PORT_LINES / FIELDS_PER_REG;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [NUM_LINES-1:0] wd;
  logic                 unused_wdata;
  assign wd           = reg_wdata[NUM_LINES-1:0];
  assign unused_wdata = ^reg_wdata;

  // trigger configuration
  logic [NUM_LINES-1:0] rise_q, rise_d, fall_q, fall_d;
  logic                 rise_en, fall_en;
  logic [PORT_LINES-1:0][SEL_W-1:0] sel_q, sel_d;
  logic                 sel_en;

  always_comb begin
    rise_en = reg_we && (int'(reg_addr) == RA_RISE);
    fall_en = reg_we && (int'(reg_addr) == RA_FALL);
    rise_d  = wd;
    fall_d  = wd;
    sel_en  = 1'b0;
    sel_d   = sel_q;
    for (int g = 0; g < SEL_REGS; g++) begin
      if (reg_we && (int'(reg_addr) == RA_SEL_BASE + g)) begin
        sel_en = 1'b1;
        for (int j = 0; j < FIELDS_PER_REG; j++)
          sel_d[g*FIELDS_PER_REG + j] = reg_wdata[j*SEL_W +: SEL_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rise_q <= '0;
      fall_q <= '0;
      sel_q  <= '0;
    end else begin
      if (rise_en) rise_q <= rise_d;
      if (fall_en) fall_q <= fall_d;
      if (sel_en)  sel_q  <= sel_d;
    end
  end

  // input selection and edge detection
  logic [NUM_LINES-1:0] line_raw, rise_hit, fall_hit, sw_trig, trig;

  eic_port_mux #(
    .NUM_LINES(NUM_LINES), .PORT_LINES(PORT_LINES),
    .NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)
  ) u_mux (
    .port_pins(port_pins), .aux_lines(aux_lines),
    .sel(sel_q), .line_raw(line_raw)
  );

  eic_edge_detect #(.NUM_LINES(NUM_LINES)) u_det (
    .clk(clk), .rst_n(rst_sync_n), .line_raw(line_raw),
    .rise_en(rise_q), .fall_en(fall_q),
    .rise_hit(rise_hit), .fall_hit(fall_hit)
  );

  assign sw_trig = (reg_we && (int'(reg_addr) == RA_SWTRIG)) ? wd : '0;
  assign trig    = rise_hit | fall_hit | sw_trig;

  // per-core mask and pending sets
  logic [NUM_CORES-1:0][NUM_LINES-1:0] imask_all, emask_all, pend_all;
  logic [NUM_CORES-1:0]                irq_all, evt_all;

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    eic_core_bank #(
      .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W),
      .IMASK_A(imask_addr(k)), .EMASK_A(emask_addr(k)), .PEND_A(pend_addr(k))
    ) u_bank (
      .clk(clk), .rst_n(rst_sync_n), .we(reg_we), .addr(reg_addr),
      .wdata(wd), .trig(trig),
      .imask(imask_all[k]), .emask(emask_all[k]), .pend(pend_all[k]),
      .irq(irq_all[k]), .evt(evt_all[k])
    );
  end

  assign irq_c0 = irq_all[0];
  assign irq_c1 = irq_all[1];
  assign evt_c0 = evt_all[0];
  assign evt_c1 = evt_all[1];

  // read path
  always_comb begin
    reg_rdata = '0;
    if (int'(reg_addr) == RA_RISE) reg_rdata[NUM_LINES-1:0] = rise_q;
    if (int'(reg_addr) == RA_FALL) reg_rdata[NUM_LINES-1:0] = fall_q;
    for (int k = 0; k < NUM_CORES; k++) begin
      if (int'(reg_addr) == imask_addr(k)) reg_rdata[NUM_LINES-1:0] = imask_all[k];
      if (int'(reg_addr) == emask_addr(k)) reg_rdata[NUM_LINES-1:0] = emask_all[k];
      if (int'(reg_addr) == pend_addr(k))  reg_rdata[NUM_LINES-1:0] = pend_all[k];
    end
    for (int g = 0; g < SEL_REGS; g++) begin
      if (int'(reg_addr) == RA_SEL_BASE + g)
        for (int j = 0; j < FIELDS_PER_REG; j++)
          reg_rdata[j*SEL_W +: SEL_W] = sel_q[g*FIELDS_PER_REG + j];
    end
  end
endmodule

// File: rtl/eic_checker.sv
module eic_checker
  import edge_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned ADDR_W    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 we,
  input logic [ADDR_W-1:0]    addr,
  input logic [NUM_LINES-1:0] wd,
  input logic [NUM_LINES-1:0] rise_hit,
  input logic [NUM_LINES-1:0] pend0,
  input logic [NUM_LINES-1:0] pend1,
  input logic                 irq0,
  input logic                 evt0,
  input logic                 evt1
);
  // R7
  pend0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we && (int'(addr) == pend_addr(0))) |-> ((pend0 & $past(pend0)) == $past(pend0)));
  // R7
  pend1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we && (int'(addr) == pend_addr(1))) |-> ((pend1 & $past(pend1)) == $past(pend1)));
  // R9
  rise_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(rise_hit) & ~pend0) == '0));
  // R8
  swtrig_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we && (int'(addr) == RA_SWTRIG)) |-> (($past(wd) & ~pend1) == '0));
  // R5
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 |-> (pend0 != '0));
  // R6
  evt_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt0 |-> (pend0 != '0)) and (evt1 |-> (pend1 != '0)));
endmodule

bind edge_irq_ctrl eic_checker #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .we(reg_we), .addr(reg_addr), .wd(wd),
  .rise_hit(rise_hit), .pend0(pend_all[0]), .pend1(pend_all[1]),
  .irq0(irq_c0), .evt0(evt_c0), .evt1(evt_c1)
);

// File: tb/edge_irq_ctrl_test.sv
module edge_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] pins = '0;
  logic [7:0]  aux = '0;
  logic        irq_c0, irq_c1, evt_c0, evt_c1;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  edge_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .port_pins(pins), .aux_lines(aux),
    .irq_c0(irq_c0), .irq_c1(irq_c1), .evt_c0(evt_c0), .evt_c1(evt_c1)
  );

  typedef struct packed { logic [3:0] a; logic [31:0] w; logic [31:0] e; } vec_t;
  localparam vec_t TBL [0:9] = '{
    '{4'd0,  32'hFFFF_FFFF, 32'h00FF_FFFF},
    '{4'd1,  32'h00A5_5A5A, 32'h00A5_5A5A},
    '{4'd3,  32'h1234_5678, 32'h0034_5678},
    '{4'd4,  32'h8765_4321, 32'h0065_4321},
    '{4'd6,  32'h0F0F_0F0F, 32'h000F_0F0F},
    '{4'd7,  32'hF0F0_F0F0, 32'h00F0_F0F0},
    '{4'd9,  32'hDEAD_BEEF, 32'h0000_BEEF},
    '{4'd12, 32'h1234_5678, 32'h0000_5678},
    '{4'd13, 32'hFFFF_FFFF, 32'h0000_0000},
    '{4'd15, 32'h1111_1111, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic settle3();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all_zero(input string req);
    logic [31:0] v;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk(req, v, 32'h0);
    end
    chk(req, {28'h0, irq_c0, irq_c1, evt_c0, evt_c1}, 32'h0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    summary();
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1 reset state
    check_all_zero("R1");

    // R2 map and read-back widths
    for (int i = 0; i < 10; i++) begin
      wr(TBL[i].a, TBL[i].w);
      rd(TBL[i].a, v);
      chk("R2", v, TBL[i].e);
    end
    rd(4'd2, v); chk("R2 swtrig reads 0", v, 32'h0);

    // R1 reset clears a dirty configuration
    do_reset();
    check_all_zero("R1");

    // R3 rising edge on line 3, port 0
    wr(4'd0, 32'h8); wr(4'd3, 32'h8);
    @(negedge clk); pins[3] = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'd5, v); chk("R3 not yet after two edges", v, 32'h0);
    @(negedge clk);
    rd(4'd5, v); chk("R3 pend c0", v, 32'h8);
    rd(4'd8, v); chk("R5 pend c1 without mask", v, 32'h8);
    chk("R5 irq", {30'h0, irq_c0, irq_c1}, 32'h2);

    // R7 write-1 clear, write-0 no effect, other core untouched
    wr(4'd5, 32'h0); rd(4'd5, v); chk("R7 write0", v, 32'h8);
    wr(4'd5, 32'h8); rd(4'd5, v); chk("R7 clear", v, 32'h0);
    rd(4'd8, v); chk("R7 other core", v, 32'h8);
    chk("R5 irq drops", {31'h0, irq_c0}, 32'h0);
    wr(4'd8, 32'h8);
    @(negedge clk); pins[3] = 1'b0; settle3();
    rd(4'd5, v); chk("R4 fall ignored when disabled", v, 32'h0);

    // R4 falling only on line 5
    wr(4'd0, 32'h0); wr(4'd1, 32'h20);
    @(negedge clk); pins[5] = 1'b1; settle3();
    rd(4'd5, v); chk("R4 rise ignored", v, 32'h0);
    @(negedge clk); pins[5] = 1'b0; settle3();
    rd(4'd5, v); chk("R4 fall", v, 32'h20);
    wr(4'd5, 32'h20); wr(4'd8, 32'h20);

    // R4 both edges on line 6
    wr(4'd0, 32'h40); wr(4'd1, 32'h40);
    @(negedge clk); pins[6] = 1'b1; settle3();
    rd(4'd5, v); chk("R4 both rise", v, 32'h40);
    wr(4'd5, 32'h40);
    @(negedge clk); pins[6] = 1'b0; settle3();
    rd(4'd5, v); chk("R4 both fall", v, 32'h40);
    wr(4'd5, 32'h40); wr(4'd8, 32'h40); wr(4'd1, 32'h0);

    // R10 line 2 from port 2 (field bits 11:8 of address 9)
    wr(4'd9, 32'h0000_0200); wr(4'd0, 32'h6);
    @(negedge clk); pins[2] = 1'b1; settle3();
    rd(4'd5, v); chk("R10 unselected port", v, 32'h0);
    @(negedge clk); pins[2*16+2] = 1'b1; settle3();
    rd(4'd5, v); chk("R10 selected port", v, 32'h4);
    wr(4'd5, 32'h4); wr(4'd8, 32'h4);
    // R10 out-of-range select on line 1 ties it low
    wr(4'd9, 32'h0000_0250);
    @(negedge clk); pins[1] = 1'b1; pins[17] = 1'b1; pins[33] = 1'b1; pins[49] = 1'b1;
    settle3();
    rd(4'd5, v); chk("R10 select out of range", v, 32'h0);

    // R11 upper line 20 from aux_lines[4]
    wr(4'd0, 32'h0010_0000);
    @(negedge clk); aux[4] = 1'b1; settle3();
    rd(4'd5, v); chk("R11 aux line", v, 32'h0010_0000);
    wr(4'd5, 32'h0010_0000); wr(4'd8, 32'h0010_0000);

    // R8 software trigger with core-1 event mask on line 7
    wr(4'd7, 32'h80);
    wr(4'd2, 32'h80);
    chk("R8 evt pulse", {30'h0, evt_c0, evt_c1}, 32'h1);
    @(negedge clk);
    chk("R6 evt one cycle", {31'h0, evt_c1}, 32'h0);
    rd(4'd5, v); chk("R8 pend c0", v, 32'h80);
    rd(4'd8, v); chk("R8 pend c1", v, 32'h80);
    wr(4'd5, 32'h80); wr(4'd8, 32'h80);

    // R6 edge event on line 8 with core-0 event mask only
    wr(4'd4, 32'h100); wr(4'd0, 32'h100);
    @(negedge clk); pins[8] = 1'b1; settle3();
    chk("R6 evt from edge", {30'h0, evt_c0, irq_c0}, 32'h2);
    @(negedge clk);
    chk("R6 evt ends", {31'h0, evt_c0}, 32'h0);
    wr(4'd5, 32'h100); wr(4'd8, 32'h100);

    // R9 edge on the same cycle as a clear
    wr(4'd0, 32'h200); wr(4'd2, 32'h200);
    @(negedge clk); pins[9] = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 4'd5; wdata = 32'h200;
    @(negedge clk); we = 1'b0;
    rd(4'd5, v); chk("R9 trigger wins", v, 32'h200);
    wr(4'd5, 32'h200); rd(4'd5, v); chk("R7 clear after", v, 32'h0);

    summary();
  end
endmodule